// File: doc/BRIEF.md
# Device Interrupt Pin Mapper

This block decides which of eight shared interrupt request lines (numbered 0 to 7, with 4 to 7 forming the upper half) carries each legacy interrupt pin (INTA to INTD) of each device slot on a PCI bus. Seven upper slots, 25 through 31, own a 16-bit route word that software reads and writes through a 16-byte little-endian register window. Each route word holds four 4-bit fields, one per pin, and the low three bits of a field pick the line. Slot 30 is a bridge whose route word is hardwired to zero; its pins always land on lines 4 to 7 in pin order. Every slot below 25 follows a fixed rotation across the upper four lines.

A lookup port takes a slot number and a pin and answers in the same cycle with a 3-bit line index, so interrupt steering logic can resolve a request without waiting. Each write through the window, whatever bytes it reaches, raises a one-cycle routing-changed pulse so that consumers of the mapping can refresh their view.

Top module: `pirq_pin_mapper`

## Requirements
- R1: After synchronous reset, the route word of programmable slot s (25 to 31, not 30) has field p (bits 4p+3:4p) equal to ((s + p) mod 4) + 4; the word of slot 25+k sits at window bytes 2k (low byte, pins INTA and INTB) and 2k+1 (high byte).
- R2: Accesses are little-endian: acc_size gives the byte count minus one, and byte i of wr_data or rd_data maps to window byte base+i.
- R3: The window base is acc_addr modulo 16; higher address bits have no effect on reads or writes.
- R4: An access that would pass byte 15 is shortened to end at byte 15: it never wraps to byte 0, and the read lanes beyond the shortened length return zero.
- R5: The bridge slot word (bytes 10 and 11) and the spare bytes 14 and 15 always read zero and ignore writes; a lookup of slot 30, pin p returns 4+p.
- R6: A lookup of a programmable slot returns bits 2:0 of that slot's field for the pin; bit 3 of the field is stored and read back but does not affect the lookup.
- R7: A lookup of any slot from 0 to 24 returns ((slot + pin) mod 4) + 4 regardless of window contents.
- R8: route_chg is high in exactly the cycle after each cycle with wr_en high, and low in every other cycle, including after reset.
- R9: The lookup and read data are combinational on the current register state; a write updates the state at the clock edge, so a read or lookup in the same cycle as a write sees the old contents.
- R10: Reset, once asserted mid-run, restores every route word to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 8 | Byte address into the register window (modulo 16) |
| acc_size | input | 2 | Access length in bytes minus one |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 32 | Little-endian write data |
| rd_data | output | 32 | Little-endian read data for the current access |
| lk_slot | input | 5 | Device slot to resolve |
| lk_pin | input | 2 | Interrupt pin to resolve (0 = INTA .. 3 = INTD) |
| lk_pirq | output | 3 | Shared interrupt line index for the slot and pin |
| route_chg | output | 1 | One-cycle pulse after each window write |

## Verification
A window write and a lookup or read of the same route word can share one cycle, and so can a write and the routing-changed pulse of the write before it. The bench raises the write strobe for slot 28 while holding the read window and lookup on that slot, samples both before the edge and expects the old word and line, then samples after the edge and expects the new ones together with the pulse. Back-to-back writes are judged by the pulse staying high for consecutive cycles and dropping one cycle after the last write.

// File: rtl/pirq_map_pkg.sv
package pirq_map_pkg;

    // Geometry of the lookup side
    localparam int SLOT_W      = 5;
    localparam int PIN_W       = 2;
    localparam int NUM_PINS    = 1 << PIN_W;
    localparam int PIRQ_W      = PIN_W + 1;
    localparam int FIELD_W     = 4;
    localparam int ROUTE_W     = NUM_PINS * FIELD_W;

    // Programmable slot range and the hardwired bridge slot
    localparam int FIRST_PROG  = 25;
    localparam int NUM_PROG    = 7;
    localparam int BRIDGE_SLOT = 30;
    localparam int PROG_IDX_W  = $clog2(NUM_PROG);

    // Register window
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 8;
    localparam int ACC_BYTES   = 4;
    localparam int SIZE_W      = $clog2(ACC_BYTES);
    localparam int DATA_W      = ACC_BYTES * BYTE_W;
    localparam int WORD_BYTES  = ROUTE_W / BYTE_W;
    localparam int WIN_BYTES   = 1 << $clog2(NUM_PROG * WORD_BYTES);
    localparam int WIN_AW      = $clog2(WIN_BYTES);
    localparam int LEN_W       = SIZE_W + 1;

    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [PIN_W-1:0]   pin_t;
    typedef logic [PIRQ_W-1:0]  pirq_t;
    typedef logic [ROUTE_W-1:0] route_word_t;
    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [WIN_AW-1:0]  win_addr_t;
    typedef logic [WIN_AW:0]    win_room_t;
    typedef logic [LEN_W-1:0]   acc_len_t;

    // One decoded window access: masked base and clipped length
    typedef struct packed {
        win_addr_t base;
        acc_len_t  nbytes;
    } win_acc_t;

    // Rotating default: upper half of the lines, offset by slot and pin
    function automatic pirq_t default_pirq(slot_t s, pin_t p);
        pin_t rot;
        rot = s[PIN_W-1:0] + p;
        return {1'b1, rot};
    endfunction

    // Reset value of a programmable slot's route word
    function automatic route_word_t default_word(int slot);
        route_word_t w;
        w = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            w[p*FIELD_W +: FIELD_W] = FIELD_W'(default_pirq(slot_t'(slot), pin_t'(p)));
        end
        return w;
    endfunction

    // Mask the address to the window and shorten an access that runs off the end
    function automatic win_acc_t decode_access(logic [ADDR_W-1:0] addr,
                                               logic [SIZE_W-1:0] size);
        win_acc_t  a;
        win_room_t room;
        acc_len_t  want;
        a.base = WIN_AW'(addr & ADDR_W'(WIN_BYTES - 1));
        want   = {1'b0, size} + acc_len_t'(1);
        room   = win_room_t'(WIN_BYTES) - {1'b0, a.base};
        if (win_room_t'(want) > room) begin
            a.nbytes = acc_len_t'(room);
        end else begin
            a.nbytes = want;
        end
        return a;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_map_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  win_acc_t                           acc,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [DATA_W-1:0]                  rd_data,
    output logic [NUM_PROG-1:0][ROUTE_W-1:0]   words
);

    byte_t win_q [WIN_BYTES];

    // One storage byte per window location; constant zero where no register lives
    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
        localparam int K    = b / WORD_BYTES;
        localparam int SLOT = FIRST_PROG + K;
        if (K >= NUM_PROG || SLOT == BRIDGE_SLOT) begin : g_fixed
            assign win_q[b] = '0;
        end else begin : g_reg
            localparam route_word_t DW = default_word(SLOT);
            localparam byte_t       DB = DW[(b % WORD_BYTES)*BYTE_W +: BYTE_W];
            logic        hit;
            logic [SIZE_W-1:0] lane;
            byte_t       byte_q;

            assign hit  = wr_en
                        && ({1'b0, acc.base} <= win_room_t'(b))
                        && (win_room_t'(b) < ({1'b0, acc.base} + win_room_t'(acc.nbytes)));
            assign lane = SIZE_W'(win_addr_t'(b) - acc.base);

            always_ff @(posedge clk) begin
                if (rst) begin
                    byte_q <= DB;
                end else if (hit) begin
                    byte_q <= wr_data[{lane, 3'b000} +: BYTE_W];
                end
            end

            assign win_q[b] = byte_q;
        end
    end

    // Little-endian read of the clipped access; lanes past the end read zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < ACC_BYTES; i++) begin
            if (acc_len_t'(i) < acc.nbytes) begin
                rd_data[i*BYTE_W +: BYTE_W] = win_q[win_addr_t'(acc.base + win_addr_t'(i))];
            end
        end
    end

    // Present the route words to the lookup
    for (genvar k = 0; k < NUM_PROG; k++) begin : g_word
        for (genvar j = 0; j < WORD_BYTES; j++) begin : g_lane
            assign words[k][j*BYTE_W +: BYTE_W] = win_q[k*WORD_BYTES + j];
        end
    end

endmodule

// File: rtl/pirq_route_lookup.sv
module pirq_route_lookup
    import pirq_map_pkg::*;
(
    input  logic [NUM_PROG-1:0][ROUTE_W-1:0] words,
    input  slot_t                            slot,
    input  pin_t                             pin,
    output pirq_t                            pirq
);

    logic                  in_prog;
    logic [PROG_IDX_W-1:0] idx;
    logic [FIELD_W-1:0]    field;

    assign in_prog = (int'(slot) >= FIRST_PROG) && (int'(slot) < FIRST_PROG + NUM_PROG);
    assign idx     = PROG_IDX_W'(slot - slot_t'(FIRST_PROG));

    always_comb begin
        field = '0;
        if (in_prog) begin
            field = words[idx][{pin, 2'b00} +: FIELD_W];
        end
    end

    always_comb begin
        if (slot == slot_t'(BRIDGE_SLOT)) begin
            pirq = {1'b1, pin};
        end else if (in_prog) begin
            pirq = field[PIRQ_W-1:0];
        end else begin
            pirq = default_pirq(slot, pin);
        end
    end

endmodule

// File: rtl/pirq_route_notify.sv
module pirq_route_notify (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    output logic route_chg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            route_chg <= 1'b0;
        end else begin
            route_chg <= wr_en;
        end
    end

endmodule

// File: rtl/pirq_pin_mapper.sv
module pirq_pin_mapper
    import pirq_map_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [SIZE_W-1:0]   acc_size,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [SLOT_W-1:0]   lk_slot,
    input  logic [PIN_W-1:0]    lk_pin,
    output logic [PIRQ_W-1:0]   lk_pirq,
    output logic                route_chg
);

    win_acc_t                         acc;
    logic [NUM_PROG-1:0][ROUTE_W-1:0] words;

    assign acc = decode_access(acc_addr, acc_size);

    pirq_route_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .acc     (acc),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .words   (words)
    );

    pirq_route_lookup u_lookup (
        .words (words),
        .slot  (lk_slot),
        .pin   (lk_pin),
        .pirq  (lk_pirq)
    );

    pirq_route_notify u_notify (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .route_chg (route_chg)
    );

endmodule

// File: rtl/pirq_map_checker.sv
module pirq_map_checker
    import pirq_map_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   acc_addr,
    input logic [SIZE_W-1:0]   acc_size,
    input logic                wr_en,
    input logic [DATA_W-1:0]   rd_data,
    input logic [SLOT_W-1:0]   lk_slot,
    input logic [PIN_W-1:0]    lk_pin,
    input logic [PIRQ_W-1:0]   lk_pirq,
    input logic                route_chg
);

    localparam int BRIDGE_BYTE = (BRIDGE_SLOT - FIRST_PROG) * WORD_BYTES;
    localparam int SPARE_BYTE  = NUM_PROG * WORD_BYTES;

    win_addr_t base;
    assign base = WIN_AW'(acc_addr & ADDR_W'(WIN_BYTES - 1));

    // R8: a write is followed by the pulse, an idle cycle by no pulse
    p_chg_after_wr_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> route_chg);
    p_chg_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !route_chg);

    // R9: without a write, a steady access reads steady data
    p_rd_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst) && $stable(acc_addr) && $stable(acc_size))
        |-> $stable(rd_data));

    // R4: an access at the last byte returns nothing in the upper lanes
    p_trunc_r4: assert property (@(posedge clk) disable iff (rst)
        (base == win_addr_t'(WIN_BYTES - 1)) |-> (rd_data[DATA_W-1:BYTE_W] == '0));

    // R5: bridge and spare words read zero
    p_resv_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (base == win_addr_t'(BRIDGE_BYTE) || base == win_addr_t'(SPARE_BYTE))
        |-> (rd_data[ROUTE_W-1:0] == '0));

    // R5: bridge pins land on the upper lines in pin order
    p_bridge_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_slot == SLOT_W'(BRIDGE_SLOT)) |-> (lk_pirq == {1'b1, lk_pin}));

    // R7: slots below the programmable range only reach the upper lines
    p_low_upper_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(lk_slot) < FIRST_PROG) |-> lk_pirq[PIRQ_W-1]);

endmodule

bind pirq_pin_mapper pirq_map_checker u_pirq_map_checker (
    .clk       (clk),
    .rst       (rst),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .lk_slot   (lk_slot),
    .lk_pin    (lk_pin),
    .lk_pirq   (lk_pirq),
    .route_chg (route_chg)
);

// File: tb/test_pirq_pin_mapper.sv
module test_pirq_pin_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  lk_slot = '0;
    logic [1:0]  lk_pin = '0;
    logic [2:0]  lk_pirq;
    logic        route_chg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pirq_pin_mapper i_pirq_pin_mapper (
        .clk       (clk),
        .rst       (rst),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .lk_slot   (lk_slot),
        .lk_pin    (lk_pin),
        .lk_pirq   (lk_pirq),
        .route_chg (route_chg)
    );

    // Lookup vectors after reset: {slot, pin, expected line}
    localparam int NVEC = 16;
    localparam logic [9:0] VEC [NVEC] = '{
        {5'd0,  2'd0, 3'd4}, {5'd0,  2'd3, 3'd7}, {5'd1,  2'd0, 3'd5},
        {5'd7,  2'd2, 3'd5}, {5'd13, 2'd1, 3'd6}, {5'd24, 2'd1, 3'd5},
        {5'd25, 2'd0, 3'd5}, {5'd25, 2'd3, 3'd4}, {5'd26, 2'd1, 3'd7},
        {5'd27, 2'd2, 3'd5}, {5'd28, 2'd3, 3'd7}, {5'd29, 2'd0, 3'd5},
        {5'd30, 2'd0, 3'd4}, {5'd30, 2'd3, 3'd7}, {5'd31, 2'd1, 3'd4},
        {5'd31, 2'd3, 3'd6}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    // Called in the low clock phase; inputs settle, then the output is sampled
    task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] v);
        acc_addr = a;
        acc_size = s;
        #1;
        v = rd_data;
    endtask

    task automatic look(input logic [4:0] s, input logic [1:0] p, output logic [2:0] v);
        lk_slot = s;
        lk_pin  = p;
        #1;
        v = lk_pirq;
    endtask

    // Write one access; returns at the next falling edge with the pulse checked
    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_addr = a;
        acc_size = s;
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
        chk("R8 pulse after write", {31'b0, route_chg}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [2:0]  q;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        chk("R8 no pulse after reset", {31'b0, route_chg}, 32'd0);
        rd(8'd0, 2'd3, v);
        chk("R1 bytes 0..3 default", v, 32'h5476_4765);
        rd(8'd8, 2'd3, v);
        chk("R5 bridge word zero at reset", v, 32'h0000_4765);
        rd(8'd12, 2'd1, v);
        chk("R1 slot 31 default", v, 32'h0000_6547);

        // Table of lookups: R5, R6, R7
        for (int i = 0; i < NVEC; i++) begin
            look(VEC[i][9:5], VEC[i][4:3], q);
            chk($sformatf("R7/R6/R5 lookup slot %0d pin %0d", VEC[i][9:5], VEC[i][4:3]),
                {29'b0, q}, {29'b0, VEC[i][2:0]});
        end

        // R2: two-byte little-endian write to slot 25
        wr(8'd0, 2'd1, 32'hFFFF_0123);
        @(negedge clk);
        chk("R8 pulse lasts one cycle", {31'b0, route_chg}, 32'd0);
        rd(8'd0, 2'd3, v);
        chk("R2 little-endian write", v, 32'h5476_0123);
        look(5'd25, 2'd0, q);
        chk("R6 slot 25 INTA", {29'b0, q}, 32'd3);
        look(5'd25, 2'd3, q);
        chk("R6 slot 25 INTD", {29'b0, q}, 32'd0);

        // R6: field bit 3 stored but ignored by the lookup
        wr(8'd2, 2'd0, 32'h0000_00F9);
        rd(8'd2, 2'd0, v);
        chk("R6 bit 3 reads back", v, 32'h0000_00F9);
        look(5'd26, 2'd0, q);
        chk("R6 slot 26 INTA ignores bit 3", {29'b0, q}, 32'd1);
        look(5'd26, 2'd1, q);
        chk("R6 slot 26 INTB ignores bit 3", {29'b0, q}, 32'd7);

        // R3: high address bits masked
        wr(8'h24, 2'd0, 32'h0000_0012);
        look(5'd27, 2'd0, q);
        chk("R3 masked write slot 27 INTA", {29'b0, q}, 32'd2);
        look(5'd27, 2'd1, q);
        chk("R3 masked write slot 27 INTB", {29'b0, q}, 32'd1);
        rd(8'h84, 2'd0, v);
        chk("R3 masked read", v, 32'h0000_0012);

        // R4: accesses past the end are shortened, never wrap
        wr(8'd13, 2'd3, 32'hAABB_CC11);
        rd(8'd12, 2'd3, v);
        chk("R4 truncated write keeps spare zero", v, 32'h0000_1147);
        look(5'd31, 2'd3, q);
        chk("R4 slot 31 INTD from truncated write", {29'b0, q}, 32'd1);
        wr(8'd15, 2'd3, 32'hDDCC_BBAA);
        rd(8'd0, 2'd0, v);
        chk("R4 no wrap to byte 0", v, 32'h0000_0023);
        rd(8'd14, 2'd3, v);
        chk("R4 read past end zero", v, 32'h0000_0000);

        // R5: bridge word ignores writes, still pulses
        wr(8'd10, 2'd1, 32'h0000_FFFF);
        rd(8'd10, 2'd1, v);
        chk("R5 bridge word ignores write", v, 32'h0000_0000);
        look(5'd30, 2'd1, q);
        chk("R5 bridge INTB fixed", {29'b0, q}, 32'd5);
        look(5'd13, 2'd1, q);
        chk("R7 low slot unaffected by writes", {29'b0, q}, 32'd6);

        // R9: write and read/lookup of the same word in one cycle
        @(negedge clk);
        acc_addr = 8'd6;
        acc_size = 2'd1;
        wr_data  = 32'h0000_3333;
        wr_en    = 1'b1;
        lk_slot  = 5'd28;
        lk_pin   = 2'd0;
        #1;
        chk("R9 read before edge sees old", rd_data, 32'h0000_7654);
        chk("R9 lookup before edge sees old", {29'b0, lk_pirq}, 32'd4);
        @(negedge clk);
        chk("R9 read after edge sees new", rd_data, 32'h0000_3333);
        chk("R9 lookup after edge sees new", {29'b0, lk_pirq}, 32'd3);
        chk("R8 pulse for same-cycle write", {31'b0, route_chg}, 32'd1);
        // second write back to back: pulse stays high
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        @(negedge clk);
        chk("R8 back-to-back pulse", {31'b0, route_chg}, 32'd1);
        @(negedge clk);
        chk("R8 pulse ends", {31'b0, route_chg}, 32'd0);

        // R10: reset restores defaults
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(8'd0, 2'd3, v);
        chk("R10 defaults restored", v, 32'h5476_4765);
        rd(8'd12, 2'd1, v);
        chk("R10 slot 31 restored", v, 32'h0000_6547);
        look(5'd28, 2'd0, q);
        chk("R10 slot 28 lookup restored", {29'b0, q}, 32'd4);

        summary();
        $finish;
    end

endmodule